// File: doc/BRIEF.md
# Programmable Clock Divider Output

This block generates a slow square wave from one reference clock. A 4-bit divisor field sets a ratio from 1 to 16. A run-time select picks the count source: either every reference cycle (the fast timebase) or a one-cycle strobe from an internal prescaler (the slow timebase). A polarity bit inverts the result. The result leaves the block as a data value and a separate drive-enable, for a tri-state pad outside the block.

Software writes the divisor, timebase select, polarity and enable together with a single write strobe. Polarity and enable take effect on the next cycle. The divisor and the timebase are held in a shadow register and adopted only at the end of the running output period, so a change never produces a shortened pulse. The pad stays undriven from reset until software sets the enable. The pin has no input function.

All pins are plain control or data pins. No stream flows through the block, so there is no valid/ready handshake.

Top module: `freqgen_out`

## Requirements
- R1: From reset, `pin_oe` is 0 and `pin_out` is 0. Both stay 0, even while the divider runs, until a write carries `cfg_oe`=1.
- R2: A divisor field value d (0 to 15) selects the ratio N = d+1. One output period spans N timebase ticks.
- R3: For N >= 2, the output (polarity 0) is high for ceil(N/2) ticks and low for floor(N/2) ticks. The duty cycle is 50% for even N, and the high phase is one tick longer for odd N.
- R4: For N = 1, the output (polarity 0) equals the timebase strobe delayed one cycle. With the fast timebase it stays high. With the slow timebase it is high for 1 cycle out of every PRESCALE cycles.
- R5: `cfg_slow`=1 selects the slow timebase, which ticks once every PRESCALE reference cycles, so every phase length scales by PRESCALE. `cfg_slow`=0 ticks on every reference cycle.
- R6: `cfg_pol`=1 inverts the output. For odd N the low phase then becomes the longer one.
- R7: A divisor or timebase change written during a period takes effect only at that period's terminal count. The period in progress completes with its old high and low lengths.
- R8: `cfg_oe` and `cfg_pol` take effect in the cycle after the write strobe. Clearing `cfg_oe` forces `pin_oe` and `pin_out` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (fast timebase) |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe; captures all cfg_* fields |
| cfg_div | input | 4 | Divisor field, ratio = value + 1 |
| cfg_slow | input | 1 | 1 selects the prescaled slow timebase |
| cfg_pol | input | 1 | 1 inverts the output |
| cfg_oe | input | 1 | 1 enables the pad driver |
| pin_out | output | 1 | Output data value, 0 while disabled |
| pin_oe | output | 1 | Pad drive enable; 0 means high-impedance |

## Verification
The divider is run through all sixteen divisor values on both timebases. For each one, the high and low phase lengths are measured separately. This separates an off-by-one in the divisor encoding from a wrong duty split on odd ratios, and it also exposes a wrong prescale factor. Ratio 1 is judged on its own pattern (constant high on the fast timebase, a single-cycle pulse on the slow one), because no edges exist to time in the fast case. An inverted-polarity odd ratio shows whether the phases swap. A divisor rewrite in the middle of a long high phase shows whether the old period completes. Enable writes, both before and after other activity, confirm that the pad stays quiet until enabled and that clearing the enable silences it.

// File: rtl/fg_pkg.sv
package fg_pkg;
  parameter int FG_DIV_W = 4;

  typedef struct packed {
    logic [FG_DIV_W-1:0] div;
    logic                slow;
  } fg_rate_t;
endpackage

// File: rtl/fg_prescale.sv
module fg_prescale #(
  parameter int PRESCALE = 100
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (PRESCALE <= 1) begin : g_bypass
      assign tick = 1'b1;
    end else begin : g_count
      localparam int CW = $clog2(PRESCALE);
      localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
      end

      assign tick = (cnt == LAST);

      // R5: two slow ticks never fall on adjacent cycles
      p_tick_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/fg_divider.sv
module fg_divider
  import fg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     slow_tick,
  input  fg_rate_t shadow,
  output logic     q
);
  localparam int CW = FG_DIV_W;

  fg_rate_t      act;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nxt;
  logic [CW:0]   hi_len;
  logic          tb;
  logic          term;

  assign tb      = act.slow ? slow_tick : 1'b1;
  assign term    = tb && (cnt == act.div);
  assign cnt_nxt = term ? '0 : cnt + 1'b1;
  assign hi_len  = ({1'b0, act.div} + (CW+1)'(2)) >> 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act <= '0;
      cnt <= '0;
      q   <= 1'b0;
    end else begin
      if (tb) begin
        cnt <= cnt_nxt;
        if (term) act <= shadow;
      end
      if (act.div == '0)
        q <= tb;
      else if (tb)
        q <= ({1'b0, cnt_nxt} < hi_len);
    end
  end

  // R2: the phase counter never passes the active divisor
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= act.div);
  // R7: the active rate changes only at a terminal count
  p_hold_rate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !term |=> $stable(act));
  // R3: between ticks the divided output holds
  p_q_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tb && act.div != '0) |=> $stable(q));
endmodule

// File: rtl/fg_drive.sv
module fg_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_we,
  input  logic cfg_pol,
  input  logic cfg_oe,
  input  logic q,
  output logic pin_out,
  output logic pin_oe
);
  logic pol_r;
  logic oe_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol_r <= 1'b0;
      oe_r  <= 1'b0;
    end else if (cfg_we) begin
      pol_r <= cfg_pol;
      oe_r  <= cfg_oe;
    end
  end

  assign pin_oe  = oe_r;
  assign pin_out = oe_r & (q ^ pol_r);

  // R8: the enable follows the written bit one cycle later
  p_oe_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (pin_oe == $past(cfg_oe)));
  // R1: without a write, a disabled pad stays disabled
  p_stay_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && !pin_oe) |=> !pin_oe);
endmodule

// File: rtl/freqgen_out.sv
module freqgen_out
  import fg_pkg::*;
#(
  parameter int PRESCALE = 100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [FG_DIV_W-1:0] cfg_div,
  input  logic                cfg_slow,
  input  logic                cfg_pol,
  input  logic                cfg_oe,
  output logic                pin_out,
  output logic                pin_oe
);
  fg_rate_t shadow;
  logic     slow_tick;
  logic     q;

  always_ff @(posedge clk) begin
    if (!rst_n)      shadow <= '0;
    else if (cfg_we) shadow <= '{div: cfg_div, slow: cfg_slow};
  end

  fg_prescale #(.PRESCALE(PRESCALE)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (slow_tick)
  );

  fg_divider u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .slow_tick (slow_tick),
    .shadow    (shadow),
    .q         (q)
  );

  fg_drive u_drv (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_we  (cfg_we),
    .cfg_pol (cfg_pol),
    .cfg_oe  (cfg_oe),
    .q       (q),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
  );
endmodule

// File: tb/sim_freqgen_out.sv
module sim_freqgen_out;
  localparam int CLK_PERIOD = 10;
  localparam int P          = 10;
  localparam int SETTLE     = 16 * P + 10;

  typedef struct {
    int    hi;
    int    lo;
    string req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_div = '0;
  logic       cfg_slow = 1'b0;
  logic       cfg_pol = 1'b0;
  logic       cfg_oe = 1'b0;
  logic       pin_out;
  logic       pin_oe;

  int   total = 0;
  int   bad = 0;
  int   n_push = 0;
  int   n_pop = 0;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  freqgen_out #(.PRESCALE(P)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_div(cfg_div),
    .cfg_slow(cfg_slow), .cfg_pol(cfg_pol), .cfg_oe(cfg_oe),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic wr(input int d, input bit slow, input bit pol, input bit oe);
    @(negedge clk);
    cfg_div = 4'(d); cfg_slow = slow; cfg_pol = pol; cfg_oe = oe; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic push_case(input int d, input bit slow, input bit pol, input string req);
    exp_t e;
    int n = d + 1;
    if (n == 1) begin
      e.hi = slow ? 1 : 0;
      e.lo = slow ? P - 1 : 0;
    end else begin
      e.hi = ((n + 1) / 2) * (slow ? P : 1);
      e.lo = (n / 2) * (slow ? P : 1);
    end
    if (pol) begin int t = e.hi; e.hi = e.lo; e.lo = t; end
    e.req = req;
    exp_q.push_back(e);
    n_push++;
    wr(d, slow, pol, 1'b1);
    wait (n_pop == n_push);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // Monitor: pops the expected item and measures the live waveform
  initial begin : monitor
    forever begin
      exp_t e;
      int   h;
      int   l;
      bit   ok;
      wait (n_push > n_pop);
      repeat (SETTLE) @(negedge clk);
      e = exp_q.pop_front();
      if (e.lo == 0) begin
        ok = 1'b1;
        for (int i = 0; i < 40; i++) begin
          @(negedge clk);
          if (pin_out !== 1'b1) ok = 1'b0;
        end
        chk(ok, e.req, "ratio-1 fast output constant high", int'(ok), 1);
      end else begin
        do @(negedge clk); while (pin_out !== 1'b0);
        do @(negedge clk); while (pin_out !== 1'b1);
        h = 0;
        while (pin_out === 1'b1) begin h++; @(negedge clk); end
        l = 0;
        while (pin_out === 1'b0) begin l++; @(negedge clk); end
        chk(h == e.hi, e.req, "high cycles", h, e.hi);
        chk(l == e.lo, e.req, "low cycles", l, e.lo);
      end
      n_pop++;
    end
  end

  // Driver
  initial begin : driver
    bit ok;
    int h;
    int l;
    int h2;
    int l2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    ok = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pin_oe !== 1'b0 || pin_out !== 1'b0) ok = 1'b0;
    end
    chk(ok, "R1", "pad quiet after reset", int'(ok), 1);

    wr(2, 1'b0, 1'b0, 1'b0);
    ok = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pin_oe !== 1'b0 || pin_out !== 1'b0) ok = 1'b0;
    end
    chk(ok, "R1", "pad quiet while divider runs without enable", int'(ok), 1);

    wr(2, 1'b0, 1'b0, 1'b1);
    chk(pin_oe === 1'b1, "R8", "enable one cycle after write", int'(pin_oe), 1);

    // R2 R3 R4 R5: every ratio on both timebases
    for (int s = 0; s < 2; s++)
      for (int d = 0; d < 16; d++)
        push_case(d, s[0], 1'b0, (d == 0) ? "R4" : (s == 1 ? "R5" : "R2/R3"));

    // R6: inverted odd ratio
    push_case(4, 1'b0, 1'b1, "R6");

    // R7: rewrite during a long high phase
    wr(15, 1'b1, 1'b0, 1'b1);
    repeat (SETTLE) @(negedge clk);
    do @(negedge clk); while (pin_out !== 1'b0);
    do @(negedge clk); while (pin_out !== 1'b1);
    h = 0;
    repeat (3) begin h++; @(negedge clk); end
    cfg_div = 4'd1; cfg_slow = 1'b0; cfg_pol = 1'b0; cfg_oe = 1'b1; cfg_we = 1'b1;
    while (pin_out === 1'b1) begin h++; @(negedge clk); cfg_we = 1'b0; end
    cfg_we = 1'b0;
    l = 0;
    while (pin_out === 1'b0) begin l++; @(negedge clk); end
    h2 = 0;
    while (pin_out === 1'b1) begin h2++; @(negedge clk); end
    l2 = 0;
    while (pin_out === 1'b0) begin l2++; @(negedge clk); end
    chk(h == 8 * P, "R7", "old high phase completes", h, 8 * P);
    chk(l == 8 * P, "R7", "old low phase completes", l, 8 * P);
    chk(h2 == 1, "R7", "new ratio high after terminal", h2, 1);
    chk(l2 == 1, "R7", "new ratio low after terminal", l2, 1);

    // R8: disabling silences the pad
    wr(1, 1'b0, 1'b0, 1'b0);
    ok = 1'b1;
    for (int i = 0; i < 10; i++) begin
      if (pin_oe !== 1'b0 || pin_out !== 1'b0) ok = 1'b0;
      @(negedge clk);
    end
    chk(ok, "R8", "pad quiet after enable cleared", int'(ok), 1);

    finish_run();
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule